// File: doc/BRIEF.md
# Joined-Half Interval Timer

A memory-mapped timer whose count register is built from two 16-bit halves. The halves are used together as one 32-bit counter, in one of two joined configurations. In the countdown configuration, the counter is loaded from the interval value and steps down on each pulse of a count strobe. When it expires it raises a status bit. It can also emit a one-cycle start pulse for an analog converter. It then either reloads and keeps running or stops.

In the clock configuration, the counter starts from zero and steps up once per pulse of a slow seconds strobe. It flags a status bit when the count reaches the 32-bit match value. Software programs the block through a simple single-cycle register bus. The block reports through a level interrupt that is the OR of the status bits left unmasked.

The interval and match values are each kept as a low half and a high half. In the joined configurations, a full-width access to the first timer's register sees both halves as one word. In the split configurations, that access touches only the low half.

Top module: `split_timer`

## Requirements
- R1: After reset every register reads zero, the timer is stopped, the interrupt is low and the converter pulse is low.
- R2: While the configuration value is below 4, a write to the first interval register at offset 0x28 stores bits 15:0 as the low half and bits 31:16 as the high half, and a read returns {high, low}. With configuration 4 or above, the write and the read cover the low half only. Offset 0x2C accesses the high half through its bits 15:0.
- R3: The match value follows the same rule as R2 at offsets 0x30 (first) and 0x34 (high half).
- R4: In configuration 0 with the run bit (bit 0 of the control register at 0x0C) set, each count strobe moves the counter one step toward zero. The strobe that finds the counter at 1 or 0 is a timeout, which sets raw status bit 0. A loaded interval of N therefore times out on the Nth strobe.
- R5: With bit 0 of the first mode register (0x04) clear, a timeout reloads the interval and counting continues, so the next timeout follows after another N strobes.
- R6: With bit 0 of the first mode register set, a timeout clears the run bit, and the control register reads it back as 0.
- R7: With control bit 5 set, each countdown timeout drives the converter pulse high for exactly the one cycle after the timeout edge.
- R8: A control write that changes the run bit restarts the counter. In configuration 0 the counter restarts from the interval value; in configuration 1 it restarts from zero. A control write that leaves the run bit unchanged keeps the count.
- R9: In configuration 1 with the run bit set, each seconds strobe steps the counter up, and reaching the 32-bit match value sets raw status bit 1.
- R10: The mask register (0x18) keeps only the bits of 0x77. The masked status (0x20) reads raw status (0x1C) AND mask, and the interrupt is high exactly when that value is nonzero.
- R11: Writing 1s to the clear register (0x24) clears those raw status bits. A status bit set in the same cycle stays set.
- R12: The two prescale registers (0x38, 0x3C) and the two prescale-match registers (0x40, 0x44) store and return their low 8 bits. Offsets with no register read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_rd | input | 1 | Read enable, data returned in the same cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when bus_rd is low |
| cnt_strobe | input | 1 | Count strobe for the countdown configuration |
| sec_strobe | input | 1 | Seconds strobe for the clock configuration |
| irq | output | 1 | Level interrupt |
| conv_start | output | 1 | One-cycle converter start pulse |

## Verification
The hardest cases are the collisions. A control write can land on the same edge as an expiry. A clear write can land on the same cycle as a new status set. A one-shot expiry can coincide with software rewriting the run bit. These cases only arise when a count strobe is held high through bus traffic. The bench therefore leaves the strobe running while it reprograms control, mode and clear. A per-cycle behavioural model then decides the expected interrupt and pulse on every edge. Restart is told apart from plain counting by stopping part way through an interval. The bench toggles the run bit there and measures how many strobes the next expiry takes.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;

  localparam int ADDR_W = 8;
  localparam int ST_W   = 7;

  localparam logic [ADDR_W-1:0] OFS_CFG     = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_MODE0   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_RAW     = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MSKD    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CLR     = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_IVAL_A  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_IVAL_B  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_MTCH_A  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_MTCH_B  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_PRE0    = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_PMT0    = 8'h40;

  localparam logic [2:0] CFG_DOWN   = 3'd0;
  localparam logic [2:0] CFG_CLOCK  = 3'd1;
  localparam logic [2:0] CFG_SPLIT  = 3'd4;

  localparam logic [ST_W-1:0] MASK_KEEP = 7'h77;
  localparam int BIT_EXPIRE = 0;
  localparam int BIT_CLKHIT = 1;

  typedef struct packed {
    logic run_b;
    logic conv_en;
    logic run_a;
  } ctrl_t;

endpackage

// File: rtl/split_timer_regs.sv
module split_timer_regs
  import split_timer_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PRE_W  = 8,
  parameter int MODE_W = 4,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ST_W-1:0]   raw_st,
  input  logic [ST_W-1:0]   mskd_st,
  input  logic [ST_W-1:0]   mask_val,
  input  logic              oneshot_done,
  output logic [2:0]        cfg,
  output logic              oneshot,
  output ctrl_t             ctrl,
  output logic              ctrl_wr,
  output logic              restart,
  output logic [DATA_W-1:0] ival,
  output logic [DATA_W-1:0] mval,
  output logic              mask_wr,
  output logic [ST_W-1:0]   clr_bits,
  output logic [DATA_W-1:0] bus_rdata
);

  logic [2:0]        cfg_q, cfg_d;
  ctrl_t             ctrl_q, ctrl_d;
  logic [HALF_W-1:0] ilo_q, ilo_d, ihi_q, ihi_d;
  logic [HALF_W-1:0] mlo_q, mlo_d, mhi_q, mhi_d;
  logic [MODE_W-1:0] mode_q [2];
  logic [PRE_W-1:0]  pre_q  [2];
  logic [PRE_W-1:0]  pmt_q  [2];
  logic              joined;

  assign joined = (cfg_q < CFG_SPLIT);

  // Paired registers (mode, prescale, prescale match) share one template
  for (genvar g = 0; g < 2; g++) begin : g_pair
    localparam logic [ADDR_W-1:0] A_MODE = OFS_MODE0 + ADDR_W'(4 * g);
    localparam logic [ADDR_W-1:0] A_PRE  = OFS_PRE0  + ADDR_W'(4 * g);
    localparam logic [ADDR_W-1:0] A_PMT  = OFS_PMT0  + ADDR_W'(4 * g);
    logic mode_we, pre_we, pmt_we;
    assign mode_we = bus_wr && (bus_addr == A_MODE);
    assign pre_we  = bus_wr && (bus_addr == A_PRE);
    assign pmt_we  = bus_wr && (bus_addr == A_PMT);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q[g] <= '0;
        pre_q[g]  <= '0;
        pmt_q[g]  <= '0;
      end else begin
        if (mode_we) mode_q[g] <= bus_wdata[MODE_W-1:0];
        if (pre_we)  pre_q[g]  <= bus_wdata[PRE_W-1:0];
        if (pmt_we)  pmt_q[g]  <= bus_wdata[PRE_W-1:0];
      end
    end
  end

  assign ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
  assign restart  = ctrl_wr && (bus_wdata[0] != ctrl_q.run_a);
  assign mask_wr  = bus_wr && (bus_addr == OFS_MASK);
  assign clr_bits = (bus_wr && (bus_addr == OFS_CLR)) ? bus_wdata[ST_W-1:0] : '0;

  always_comb begin
    cfg_d  = cfg_q;
    ctrl_d = ctrl_q;
    ilo_d  = ilo_q;
    ihi_d  = ihi_q;
    mlo_d  = mlo_q;
    mhi_d  = mhi_q;
    if (ctrl_wr) begin
      ctrl_d.run_a   = bus_wdata[0];
      ctrl_d.conv_en = bus_wdata[5];
      ctrl_d.run_b   = bus_wdata[8];
    end else if (oneshot_done) begin
      ctrl_d.run_a = 1'b0;
    end
    if (bus_wr) begin
      unique case (bus_addr)
        OFS_CFG: cfg_d = bus_wdata[2:0];
        OFS_IVAL_A: begin
          ilo_d = bus_wdata[HALF_W-1:0];
          if (joined) ihi_d = bus_wdata[DATA_W-1:HALF_W];
        end
        OFS_IVAL_B: ihi_d = bus_wdata[HALF_W-1:0];
        OFS_MTCH_A: begin
          mlo_d = bus_wdata[HALF_W-1:0];
          if (joined) mhi_d = bus_wdata[DATA_W-1:HALF_W];
        end
        OFS_MTCH_B: mhi_d = bus_wdata[HALF_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ctrl_q <= '0;
      ilo_q  <= '0;
      ihi_q  <= '0;
      mlo_q  <= '0;
      mhi_q  <= '0;
    end else begin
      cfg_q  <= cfg_d;
      ctrl_q <= ctrl_d;
      ilo_q  <= ilo_d;
      ihi_q  <= ihi_d;
      mlo_q  <= mlo_d;
      mhi_q  <= mhi_d;
    end
  end

  assign cfg     = cfg_q;
  assign ctrl    = ctrl_q;
  assign oneshot = mode_q[0][0];
  assign ival    = {ihi_q, ilo_q};
  assign mval    = {mhi_q, mlo_q};

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_CFG:            bus_rdata = DATA_W'(cfg_q);
        OFS_MODE0:          bus_rdata = DATA_W'(mode_q[0]);
        OFS_MODE0 + 8'h04:  bus_rdata = DATA_W'(mode_q[1]);
        OFS_CTRL:           bus_rdata = DATA_W'({ctrl_q.run_b, 2'b00, ctrl_q.conv_en,
                                                 4'b0000, ctrl_q.run_a});
        OFS_MASK:           bus_rdata = DATA_W'(mask_val);
        OFS_RAW:            bus_rdata = DATA_W'(raw_st);
        OFS_MSKD:           bus_rdata = DATA_W'(mskd_st);
        OFS_IVAL_A:         bus_rdata = joined ? {ihi_q, ilo_q} : DATA_W'(ilo_q);
        OFS_IVAL_B:         bus_rdata = DATA_W'(ihi_q);
        OFS_MTCH_A:         bus_rdata = joined ? {mhi_q, mlo_q} : DATA_W'(mlo_q);
        OFS_MTCH_B:         bus_rdata = DATA_W'(mhi_q);
        OFS_PRE0:           bus_rdata = DATA_W'(pre_q[0]);
        OFS_PRE0 + 8'h04:   bus_rdata = DATA_W'(pre_q[1]);
        OFS_PMT0:           bus_rdata = DATA_W'(pmt_q[0]);
        OFS_PMT0 + 8'h04:   bus_rdata = DATA_W'(pmt_q[1]);
        default:            bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/split_timer_count.sv
module split_timer_count
  import split_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cfg,
  input  logic             run,
  input  logic             oneshot,
  input  logic             conv_en,
  input  logic             restart,
  input  logic [CNT_W-1:0] ival,
  input  logic [CNT_W-1:0] mval,
  input  logic             cnt_strobe,
  input  logic             sec_strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             clk_hit,
  output logic             oneshot_done,
  output logic             conv_start
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_up;
  logic             conv_q, conv_d;
  logic             down_step, up_step;

  assign down_step = run && (cfg == CFG_DOWN)  && cnt_strobe && !restart;
  assign up_step   = run && (cfg == CFG_CLOCK) && sec_strobe && !restart;
  assign cnt_up    = cnt_q + CNT_W'(1);

  assign expire       = down_step && (cnt_q <= CNT_W'(1));
  assign clk_hit      = up_step && (cnt_up == mval);
  assign oneshot_done = expire && oneshot;

  always_comb begin
    cnt_d  = cnt_q;
    conv_d = expire && conv_en;
    if (restart) begin
      cnt_d = (cfg == CFG_CLOCK) ? '0 : ival;
    end else if (expire) begin
      cnt_d = ival;
    end else if (down_step) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else if (up_step) begin
      cnt_d = cnt_up;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      conv_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      conv_q <= conv_d;
    end
  end

  assign cnt        = cnt_q;
  assign conv_start = conv_q;

endmodule

// File: rtl/split_timer_status.sv
module split_timer_status
  import split_timer_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            expire,
  input  logic            clk_hit,
  input  logic [ST_W-1:0] clr_bits,
  input  logic            mask_wr,
  input  logic [ST_W-1:0] mask_wdata,
  output logic [ST_W-1:0] raw_st,
  output logic [ST_W-1:0] mskd_st,
  output logic [ST_W-1:0] mask_val,
  output logic            irq
);

  logic [ST_W-1:0] raw_q, raw_d, mask_q, mask_d, set_v;

  always_comb begin
    set_v             = '0;
    set_v[BIT_EXPIRE] = expire;
    set_v[BIT_CLKHIT] = clk_hit;
    raw_d  = (raw_q & ~clr_bits) | set_v;
    mask_d = mask_wr ? (mask_wdata & MASK_KEEP) : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

  assign raw_st   = raw_q;
  assign mask_val = mask_q;
  assign mskd_st  = raw_q & mask_q;
  assign irq      = |mskd_st;

endmodule

// File: rtl/split_timer.sv
module split_timer
  import split_timer_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int PRE_W  = 8,
  parameter int MODE_W = 4,
  localparam int DATA_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cnt_strobe,
  input  logic              sec_strobe,
  output logic              irq,
  output logic              conv_start
);

  logic [2:0]        cfg;
  logic              oneshot, ctrl_wr, restart, mask_wr;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] ival, mval, cnt;
  logic [ST_W-1:0]   clr_bits, raw_st, mskd_st, mask_val;
  logic              expire, clk_hit, oneshot_done;

  split_timer_regs #(
    .HALF_W(HALF_W), .PRE_W(PRE_W), .MODE_W(MODE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .raw_st(raw_st), .mskd_st(mskd_st), .mask_val(mask_val),
    .oneshot_done(oneshot_done),
    .cfg(cfg), .oneshot(oneshot), .ctrl(ctrl), .ctrl_wr(ctrl_wr), .restart(restart),
    .ival(ival), .mval(mval), .mask_wr(mask_wr), .clr_bits(clr_bits),
    .bus_rdata(bus_rdata)
  );

  split_timer_count #(.CNT_W(DATA_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .cfg(cfg), .run(ctrl.run_a), .oneshot(oneshot), .conv_en(ctrl.conv_en),
    .restart(restart), .ival(ival), .mval(mval),
    .cnt_strobe(cnt_strobe), .sec_strobe(sec_strobe),
    .cnt(cnt), .expire(expire), .clk_hit(clk_hit),
    .oneshot_done(oneshot_done), .conv_start(conv_start)
  );

  split_timer_status u_status (
    .clk(clk), .rst_n(rst_n),
    .expire(expire), .clk_hit(clk_hit), .clr_bits(clr_bits),
    .mask_wr(mask_wr), .mask_wdata(bus_wdata[ST_W-1:0]),
    .raw_st(raw_st), .mskd_st(mskd_st), .mask_val(mask_val), .irq(irq)
  );

endmodule

// File: rtl/split_timer_chk.sv
module split_timer_chk
  import split_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       cfg,
  input ctrl_t            ctrl,
  input logic             ctrl_wr,
  input logic             wbit0,
  input logic             oneshot,
  input logic             cnt_strobe,
  input logic             sec_strobe,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] ival,
  input logic             expire,
  input logic [ST_W-1:0]  raw_st,
  input logic [ST_W-1:0]  mask_val,
  input logic             irq,
  input logic             conv_start
);

  // R4: an ordinary strobe moves the count down by exactly one
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.run_a && cfg == CFG_DOWN && cnt_strobe && cnt > CNT_W'(1) && !ctrl_wr)
    |=> cnt == $past(cnt) - CNT_W'(1));

  // R6: a one-shot expiry without a competing control write stops the timer
  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && oneshot && !ctrl_wr) |=> !ctrl.run_a);

  // R7: a converter pulse always comes with the expiry status bit
  p_conv_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> raw_st[BIT_EXPIRE]);

  // R8: toggling the run bit in countdown reloads the interval
  p_restart_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wbit0 != ctrl.run_a && cfg == CFG_DOWN) |=> cnt == $past(ival));

  // R9: the clock count holds between seconds strobes
  p_clock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == CFG_CLOCK && !sec_strobe && !ctrl_wr) |=> $stable(cnt));

  // R10: interrupt level follows unmasked status; mask never holds dropped bits
  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((raw_st & mask_val) != '0));
  p_mask_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_val & ~MASK_KEEP) == '0);

endmodule

bind split_timer split_timer_chk #(.CNT_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .ctrl(ctrl), .ctrl_wr(ctrl_wr),
  .wbit0(bus_wdata[0]), .oneshot(oneshot), .cnt_strobe(cnt_strobe),
  .sec_strobe(sec_strobe), .cnt(cnt), .ival(ival), .expire(expire),
  .raw_st(raw_st), .mask_val(mask_val), .irq(irq), .conv_start(conv_start)
);

// File: tb/split_timer_test.sv
module split_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_wr = 1'b0, b_rd = 1'b0, b_tick = 1'b0, b_sec = 1'b0;
  logic [7:0]  b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] rdata;
  logic        irq, conv_start;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  split_timer uut (
    .clk(clk), .rst_n(rst_n),
    .bus_wr(b_wr), .bus_rd(b_rd), .bus_addr(b_addr), .bus_wdata(b_wdata),
    .bus_rdata(rdata), .cnt_strobe(b_tick), .sec_strobe(b_sec),
    .irq(irq), .conv_start(conv_start)
  );

  // ---------------- behavioural reference model ----------------
  logic [2:0]  m_cfg;
  logic        m_os, m_run, m_conv_en, m_runb, m_conv;
  logic [15:0] m_ilo, m_ihi, m_mlo, m_mhi;
  logic [6:0]  m_ris, m_mask;
  logic [31:0] m_cnt;
  logic        x_cw, x_rs, x_dn, x_up, x_to, x_hit;
  logic [6:0]  x_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_os = 0; m_run = 0; m_conv_en = 0; m_runb = 0; m_conv = 0;
      m_ilo = 0; m_ihi = 0; m_mlo = 0; m_mhi = 0; m_ris = 0; m_mask = 0; m_cnt = 0;
    end else begin
      x_cw  = b_wr && b_addr == 8'h0C;
      x_rs  = x_cw && (b_wdata[0] != m_run);
      x_dn  = m_run && m_cfg == 0 && b_tick && !x_rs;
      x_up  = m_run && m_cfg == 1 && b_sec && !x_rs;
      x_to  = x_dn && (m_cnt <= 1);
      x_hit = x_up && ((m_cnt + 32'd1) == {m_mhi, m_mlo});
      x_clr = (b_wr && b_addr == 8'h24) ? b_wdata[6:0] : 7'd0;
      m_conv = x_to && m_conv_en;
      if (x_rs)       m_cnt = (m_cfg == 1) ? 32'd0 : {m_ihi, m_ilo};
      else if (x_to)  m_cnt = {m_ihi, m_ilo};
      else if (x_dn)  m_cnt = m_cnt - 1;
      else if (x_up)  m_cnt = m_cnt + 1;
      m_ris = (m_ris & ~x_clr) | {5'd0, x_hit, x_to};
      if (x_cw) begin
        m_run = b_wdata[0]; m_conv_en = b_wdata[5]; m_runb = b_wdata[8];
      end else if (x_to && m_os) m_run = 0;
      if (b_wr) begin
        case (b_addr)
          8'h00: m_cfg = b_wdata[2:0];
          8'h04: m_os = b_wdata[0];
          8'h18: m_mask = b_wdata[6:0] & 7'h77;
          8'h28: begin m_ilo = b_wdata[15:0]; if (m_cfg < 4) m_ihi = b_wdata[31:16]; end
          8'h2C: m_ihi = b_wdata[15:0];
          8'h30: begin m_mlo = b_wdata[15:0]; if (m_cfg < 4) m_mhi = b_wdata[31:16]; end
          8'h34: m_mhi = b_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks += 2;
      if (irq !== (|(m_ris & m_mask))) begin
        errors++;
        $display("FAIL R10 irq per-cycle: actual %b expected %b at %0t", irq, |(m_ris & m_mask), $time);
      end
      if (conv_start !== m_conv) begin
        errors++;
        $display("FAIL R7 conv_start per-cycle: actual %b expected %b at %0t", conv_start, m_conv, $time);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    b_wr = 1; b_addr = a; b_wdata = d;
    @(negedge clk);
    b_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    b_rd = 1; b_addr = a;
    #1;
    check(tag, rdata, exp);
    b_rd = 0;
  endtask

  // Count strobe cycles until the chosen output rises; 0 if not within 40
  task automatic run_until(input bit use_conv, output int n);
    n = 0;
    b_tick = 1;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      if ((use_conv ? conv_start : irq) === 1'b1) begin n = i; break; end
    end
    b_tick = 0;
  endtask

  task automatic sec_pulse();
    @(negedge clk); b_sec = 1;
    @(negedge clk); b_sec = 0;
  endtask

  initial begin : watchdog
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 conv_start", conv_start, 0);
    rd(8'h00, 0, "R1 cfg");
    rd(8'h0C, 0, "R1 ctrl");
    rd(8'h28, 0, "R1 interval");
    rd(8'h1C, 0, "R1 raw status");

    // R2/R3 joined halves
    wr(8'h28, 32'h0003_0010);
    rd(8'h28, 32'h0003_0010, "R2 joined read");
    rd(8'h2C, 32'h0000_0003, "R2 high half");
    wr(8'h30, 32'h1234_5678);
    rd(8'h30, 32'h1234_5678, "R3 joined match");
    rd(8'h34, 32'h0000_1234, "R3 match high");
    wr(8'h00, 32'h4);
    wr(8'h28, 32'hABCD_0007);
    rd(8'h28, 32'h0000_0007, "R2 split read");
    rd(8'h2C, 32'h0000_0003, "R2 split keeps high");
    wr(8'h30, 32'hFFFF_0009);
    rd(8'h34, 32'h0000_1234, "R3 split keeps high");
    wr(8'h00, 32'h0);
    rd(8'h28, 32'h0003_0007, "R2 rejoined");

    // R12 storage and unsupported offsets
    wr(8'h38, 32'h1FF);
    rd(8'h38, 32'hFF, "R12 prescale");
    wr(8'h44, 32'h22);
    rd(8'h44, 32'h22, "R12 prescale match");
    rd(8'h40, 32'h0, "R12 other prescale match");
    rd(8'h10, 32'h0, "R12 unsupported offset");

    // R10 mask keep bits
    wr(8'h18, 32'hFF);
    rd(8'h18, 32'h77, "R10 mask bits");

    // R4 countdown of 5
    wr(8'h28, 32'h5);
    wr(8'h0C, 32'h1);
    run_until(0, n);
    check("R4 strobes to expiry", n, 5);
    rd(8'h1C, 32'h1, "R4 raw status bit0");
    rd(8'h20, 32'h1, "R10 masked status");

    // R11 clear, then R5 periodic
    wr(8'h24, 32'h1);
    rd(8'h1C, 32'h0, "R11 cleared");
    check("R11 irq low after clear", irq, 0);
    run_until(0, n);
    check("R5 periodic second expiry", n, 5);

    // R11 clear while strobing keeps model and design in step (collision cases)
    b_tick = 1;
    wr(8'h24, 32'h1);
    wr(8'h24, 32'h1);
    b_tick = 0;

    // R7 converter pulse
    wr(8'h0C, 32'h0);
    wr(8'h24, 32'h7F);
    wr(8'h0C, 32'h1);
    wr(8'h0C, 32'h21);
    run_until(1, n);
    check("R7 strobes to pulse", n, 5);
    @(negedge clk);
    check("R7 pulse one cycle", conv_start, 0);

    // R6 one-shot
    wr(8'h0C, 32'h0);
    wr(8'h04, 32'h1);
    wr(8'h24, 32'h7F);
    wr(8'h0C, 32'h1);
    b_tick = 1;
    repeat (8) @(negedge clk);
    b_tick = 0;
    rd(8'h0C, 32'h0, "R6 run bit cleared");
    rd(8'h1C, 32'h1, "R6 one expiry flagged");

    // R8 restart mid-interval
    wr(8'h04, 32'h0);
    wr(8'h24, 32'h7F);
    wr(8'h0C, 32'h1);
    b_tick = 1;
    repeat (3) @(negedge clk);
    b_tick = 0;
    wr(8'h0C, 32'h0);
    wr(8'h0C, 32'h1);
    run_until(0, n);
    check("R8 restart from interval", n, 5);

    // R9 clock configuration
    wr(8'h0C, 32'h0);
    wr(8'h24, 32'h7F);
    wr(8'h00, 32'h1);
    wr(8'h30, 32'h3);
    wr(8'h18, 32'h2);
    wr(8'h0C, 32'h1);
    sec_pulse();
    sec_pulse();
    @(negedge clk);
    check("R9 no hit before match", irq, 0);
    rd(8'h1C, 32'h0, "R9 raw before match");
    sec_pulse();
    @(negedge clk);
    check("R9 irq on match", irq, 1);
    rd(8'h1C, 32'h2, "R9 raw bit1");

    // R10 masking removes interrupt
    wr(8'h18, 32'h0);
    check("R10 irq masked", irq, 0);
    rd(8'h20, 32'h0, "R10 masked status zero");
    rd(8'h1C, 32'h2, "R10 raw unaffected");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule